// File: doc/BRIEF.md
# Flagged Four-Bit Calculator ALU

This block is a purely combinational arithmetic and logic unit for a small calculator datapath. It takes two unsigned operands and a three-bit operation code. It returns a result one bit wider than the operands, together with carry, negative and overflow flags. Each operand gets a leading zero before any operation. The extra top bit of the result therefore holds the carry of a sum or the borrow of a difference.

There is no clock and no stored state. Outputs follow the inputs directly, so the surrounding datapath decides when the result is captured. Operation codes that name no operation give an all-ones result, which the downstream logic can recognise as invalid.

The operand width is a parameter, with a default of 4. A second parameter chooses how the adder is built: either a plain arithmetic expression or an explicit bit-level carry chain.

Top module: `flag_alu`

## Requirements
- R1: With `op_sel` = 000, `result` is (A + B) taken over DATA_W+1 bits, and `carry_flag` equals bit DATA_W of `result`. This includes carries that ripple up from the low bits.
- R2: With `op_sel` = 001, `result` is (A − B) modulo 2^(DATA_W+1), which is the two's-complement wrap when B > A.
- R3: With `op_sel` = 001, `neg_flag` and `ovf_flag` are both 1 exactly when B > A, and `carry_flag` is 0.
- R4: With `op_sel` = 010, `result` is A + A over DATA_W+1 bits, and `carry_flag` equals bit DATA_W of `result`.
- R5: With `op_sel` = 011, 100 and 101, `result` is the bitwise AND, OR and XOR of the zero-extended operands, so bit DATA_W is 0.
- R6: For the three logic codes, `carry_flag`, `neg_flag` and `ovf_flag` are all 0.
- R7: With `op_sel` = 110 or 111, `result` is all ones and every flag is 0.
- R8: `neg_flag` always equals `ovf_flag`. For the add and double codes both are 0. With all inputs zero, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | DATA_W | First operand A, unsigned |
| op_b | input | DATA_W | Second operand B, unsigned |
| op_sel | input | 3 | Operation code |
| result | output | DATA_W+1 | Zero-extended operation result |
| carry_flag | output | 1 | Carry out of add or double |
| neg_flag | output | 1 | Subtraction result is negative |
| ovf_flag | output | 1 | Subtraction wrapped below zero |

## Verification
The bench instantiates the block with DATA_W = 4 and ADDER_STYLE = 1, which selects the explicit carry chain. With four-bit operands, all 256 operand pairs can be applied under each of the eight operation codes. That covers every carry ripple into bit 4, every borrow case, and both unused codes. The carry-chain variant is chosen because its per-bit propagate and generate logic is where a wrong carry would hide. The behavioural variant is covered by the same in-module assertions whenever it is chosen.

// File: rtl/calc_alu_pkg.sv
package calc_alu_pkg;

   localparam int SEL_W = 3;

   localparam logic [SEL_W-1:0] SEL_ADD = 3'b000;
   localparam logic [SEL_W-1:0] SEL_SUB = 3'b001;
   localparam logic [SEL_W-1:0] SEL_DBL = 3'b010;
   localparam logic [SEL_W-1:0] SEL_AND = 3'b011;
   localparam logic [SEL_W-1:0] SEL_OR  = 3'b100;
   localparam logic [SEL_W-1:0] SEL_XOR = 3'b101;

   // One-hot classification of the operation code
   typedef struct packed {
      logic add;
      logic sub;
      logic dbl;
      logic land;
      logic lor;
      logic lxor;
      logic bad;
   } op_class_t;

   typedef enum logic [1:0] {
      LOGIC_AND = 2'd0,
      LOGIC_OR  = 2'd1,
      LOGIC_XOR = 2'd2,
      LOGIC_OFF = 2'd3
   } logic_fn_t;

endpackage

// File: rtl/calc_op_decode.sv
module calc_op_decode
   import calc_alu_pkg::*;
(
   input  logic [SEL_W-1:0] op_sel,
   output op_class_t        cls,
   output logic_fn_t        lfn
);

   always_comb begin
      cls = '0;
      lfn = LOGIC_OFF;
      unique case (op_sel)
         SEL_ADD: cls.add = 1'b1;
         SEL_SUB: cls.sub = 1'b1;
         SEL_DBL: cls.dbl = 1'b1;
         SEL_AND: begin cls.land = 1'b1; lfn = LOGIC_AND; end
         SEL_OR:  begin cls.lor  = 1'b1; lfn = LOGIC_OR;  end
         SEL_XOR: begin cls.lxor = 1'b1; lfn = LOGIC_XOR; end
         default: cls.bad = 1'b1;
      endcase
   end

   // R7: every code maps to exactly one class, so the unused codes land in bad
   always_comb begin
      assert_decode_onehot_R7: assert ($countones(cls) == 1)
         else $error("decoder produced %0d active classes", $countones(cls));
   end

endmodule

// File: rtl/calc_arith_core.sv
module calc_arith_core #(
   parameter int DATA_W      = 4,
   parameter int ADDER_STYLE = 0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              do_sub,
   input  logic              do_dbl,
   output logic [DATA_W:0]   sum
);

   localparam int RES_W = DATA_W + 1;

   logic [RES_W-1:0] x_ext;
   logic [RES_W-1:0] y_sel;
   logic [RES_W-1:0] y_ext;
   logic             cin;

   always_comb begin
      x_ext = {1'b0, a};
      y_sel = do_dbl ? {1'b0, a} : {1'b0, b};
      y_ext = do_sub ? ~y_sel : y_sel;
      cin   = do_sub;
   end

   generate
      if (ADDER_STYLE == 0) begin : g_behav
         assign sum = x_ext + y_ext + RES_W'(cin);
      end else begin : g_ripple
         logic [RES_W-1:0] cch;
         assign cch[0] = cin;
         for (genvar i = 0; i < RES_W; i++) begin : g_bit
            logic prop;
            logic gen;
            assign prop   = x_ext[i] ^ y_ext[i];
            assign gen    = x_ext[i] & y_ext[i];
            assign sum[i] = prop ^ cch[i];
            if (i < RES_W - 1) begin : g_carry
               assign cch[i+1] = gen | (prop & cch[i]);
            end
         end
      end
   endgenerate

   // R1 R2 R4: the adder output agrees with integer arithmetic on the operands
   always_comb begin
      if (!do_sub && !do_dbl) begin
         assert_add_sum_R1: assert (int'(sum) == int'(a) + int'(b))
            else $error("add sum %0d for %0d+%0d", sum, a, b);
      end
      if (do_dbl && !do_sub) begin
         assert_dbl_sum_R4: assert (int'(sum) == 2 * int'(a))
            else $error("double sum %0d for %0d", sum, a);
      end
      if (do_sub && !do_dbl) begin
         assert_sub_wrap_R2: assert (int'(sum) == ((int'(a) - int'(b)) & ((1 << RES_W) - 1)))
            else $error("difference %0d for %0d-%0d", sum, a, b);
      end
   end

endmodule

// File: rtl/calc_logic_core.sv
module calc_logic_core
   import calc_alu_pkg::*;
#(
   parameter int DATA_W = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic_fn_t         fn,
   output logic [DATA_W:0]   res
);

   localparam int RES_W = DATA_W + 1;

   logic [RES_W-1:0] xa;
   logic [RES_W-1:0] xb;

   assign xa = {1'b0, a};
   assign xb = {1'b0, b};

   for (genvar i = 0; i < RES_W; i++) begin : g_lane
      always_comb begin
         unique case (fn)
            LOGIC_AND: res[i] = xa[i] & xb[i];
            LOGIC_OR:  res[i] = xa[i] | xb[i];
            LOGIC_XOR: res[i] = xa[i] ^ xb[i];
            default:   res[i] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import calc_alu_pkg::*;
#(
   parameter int DATA_W      = 4,
   parameter int ADDER_STYLE = 0
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [SEL_W-1:0]  op_sel,
   output logic [DATA_W:0]   result,
   output logic              carry_flag,
   output logic              neg_flag,
   output logic              ovf_flag
);

   localparam int RES_W = DATA_W + 1;

   generate
      if (DATA_W < 1 || DATA_W > 30) begin : g_chk_width
         $error("flag_alu: DATA_W must lie in 1..30");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_chk_style
         $error("flag_alu: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   op_class_t        cls;
   logic_fn_t        lfn;
   logic [RES_W-1:0] arith_sum;
   logic [RES_W-1:0] logic_res;

   calc_op_decode u_decode (
      .op_sel (op_sel),
      .cls    (cls),
      .lfn    (lfn)
   );

   calc_arith_core #(
      .DATA_W      (DATA_W),
      .ADDER_STYLE (ADDER_STYLE)
   ) u_arith (
      .a      (op_a),
      .b      (op_b),
      .do_sub (cls.sub),
      .do_dbl (cls.dbl),
      .sum    (arith_sum)
   );

   calc_logic_core #(
      .DATA_W (DATA_W)
   ) u_logic (
      .a   (op_a),
      .b   (op_b),
      .fn  (lfn),
      .res (logic_res)
   );

   always_comb begin
      result     = '1;
      carry_flag = 1'b0;
      neg_flag   = 1'b0;
      ovf_flag   = 1'b0;
      if (cls.add || cls.dbl) begin
         result     = arith_sum;
         carry_flag = arith_sum[DATA_W];
      end else if (cls.sub) begin
         result   = arith_sum;
         neg_flag = arith_sum[DATA_W];
         ovf_flag = arith_sum[DATA_W];
      end else if (cls.land || cls.lor || cls.lxor) begin
         result = logic_res;
      end
   end

   // Port-level checks against independent comparisons of the inputs
   always_comb begin
      if (op_sel == SEL_SUB) begin
         assert_sub_flags_R3: assert (neg_flag == (op_b > op_a) && ovf_flag == (op_b > op_a) && !carry_flag)
            else $error("subtract flags n=%b o=%b c=%b", neg_flag, ovf_flag, carry_flag);
      end
      if (op_sel == SEL_AND || op_sel == SEL_OR || op_sel == SEL_XOR) begin
         assert_logic_quiet_R6: assert (!carry_flag && !neg_flag && !ovf_flag && !result[DATA_W])
            else $error("logic op raised a flag or top bit");
      end
      assert_neg_ovf_pair_R8: assert (neg_flag == ovf_flag)
         else $error("negative and overflow flags differ");
   end

endmodule

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;

   localparam int DW = 4;
   localparam int RW = DW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] op_a = '0;
   logic [DW-1:0] op_b = '0;
   logic [2:0]    op_sel = '0;
   logic [RW-1:0] result;
   logic          carry_flag, neg_flag, ovf_flag;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [RW-1:0] r;
      logic          c;
      logic          n;
      logic          o;
      string         tag;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;

   flag_alu #(.DATA_W(DW), .ADDER_STYLE(1)) u_flag_alu (
      .op_a       (op_a),
      .op_b       (op_b),
      .op_sel     (op_sel),
      .result     (result),
      .carry_flag (carry_flag),
      .neg_flag   (neg_flag),
      .ovf_flag   (ovf_flag)
   );

   function automatic exp_t model(int a, int b, int s);
      exp_t e;
      int   mask = (1 << RW) - 1;
      e.c = 1'b0; e.n = 1'b0; e.o = 1'b0;
      case (s)
         0: begin e.r = RW'((a + b) & mask); e.c = e.r[DW]; e.tag = "R1"; end
         1: begin e.r = RW'((a - b) & mask); e.n = (b > a); e.o = (b > a); e.tag = "R2/R3"; end
         2: begin e.r = RW'((2 * a) & mask); e.c = e.r[DW]; e.tag = "R4"; end
         3: begin e.r = RW'(a & b); e.tag = "R5/R6 and"; end
         4: begin e.r = RW'(a | b); e.tag = "R5/R6 or"; end
         5: begin e.r = RW'(a ^ b); e.tag = "R5/R6 xor"; end
         default: begin e.r = '1; e.tag = "R7"; end
      endcase
      return e;
   endfunction

   task automatic drive(int a, int b, int s, string extra);
      exp_t e;
      @(posedge clk);
      op_a   = DW'(a);
      op_b   = DW'(b);
      op_sel = 3'(s);
      e = model(a, b, s);
      if (extra.len() > 0) e.tag = extra;
      sb.push_back(e);
   endtask

   // Monitor: compares at the falling edge, half a cycle after the drive
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (result !== e.r || carry_flag !== e.c || neg_flag !== e.n || ovf_flag !== e.o) begin
               fails++;
               $display("FAIL %s: got r=%0d c=%b n=%b o=%b expected r=%0d c=%b n=%b o=%b (a=%0d b=%0d sel=%0d)",
                        e.tag, result, carry_flag, neg_flag, ovf_flag, e.r, e.c, e.n, e.o, op_a, op_b, op_sel);
            end
            checks++;
            if (neg_flag !== ovf_flag) begin
               fails++;
               $display("FAIL R8: neg=%b ovf=%b expected equal", neg_flag, ovf_flag);
            end
         end
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      // R8: all-zero inputs give a zero result and quiet flags
      drive(0, 0, 0, "R8 zero");
      // R1: carry rippling from the lowest bit into bit 4
      drive(15, 1, 0, "R1 ripple carry");
      // R3: equal operands are not negative
      drive(9, 9, 1, "R3 equal");
      // R2 R3: smallest negative wrap
      drive(0, 1, 1, "R2/R3 wrap 31");
      // R4: top-bit double
      drive(8, 0, 2, "R4 carry");
      // R7: both unused codes
      drive(5, 10, 6, "R7 code6");
      drive(5, 10, 7, "R7 code7");
      for (int s = 0; s < 8; s++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               drive(a, b, s, "");
      @(posedge clk);
      @(negedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #150000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule